// File: doc/BRIEF.md
# Multi-channel offset PWM generator

A bank of pulse-width channels controlled through a small 32-bit register port with byte addresses in 4-byte word steps. Each channel has three 32-bit counts: a period, a high-time (duty) and a delay (offset) that places the pulse inside the period. Software writes these counts into shadow registers, which have no effect on the outputs. A single load command then moves every channel's shadow counts into the working counters at once and restarts all channels together, so their periods stay in phase.

In immediate mode the load acts on the next clock. In aligned mode the load is held pending. Each enabled channel runs to the end of its current period and then waits with its output low. When the last enabled channel has finished its period, all channels start their new settings on the same clock. A core-reset bit in the control register keeps every channel idle with its output low. Clearing that bit starts all channels from phase zero.

Besides the channel arrays, the register port provides a fixed identification word, a scratchpad, the channel count and a mode register. A read returns its data one clock after the read strobe.

Top module: `pwm_bank`

## Requirements
- R1: A read presents its data on rd_data in the cycle after rd_en. Address 0x0C reads 0x601A3471, address 0x14 reads the channel count NCH, and address 0x08 is a 32-bit scratchpad that reads back the last value written to it.
- R2: Writes go to shadow registers: period at 0x40+4·ch, duty at 0x80+4·ch and offset at 0xC0+4·ch. Each shadow reads back the value written to it, and a write leaves pwm_out unchanged until a load takes place.
- R3: Writing 1 to bit 1 of the control register (0x10) is a load command. When bit 1 of the mode register (0x18) is 1, the load copies every channel's shadow counts on that clock, and all channels show phase 0 of the new settings in the next cycle.
- R4: Bit 0 of the control register resets to 1. While it is 1, every output is low and every phase is held at 0. After it is written 0, all channels show phase 0 in the cycle that follows the write.
- R5: With phase p running from 0 to period−1, a channel's output is 1 exactly when offset ≤ p < offset+duty. The pulse never wraps past the end of the period.
- R6: A duty count larger than the period behaves like a duty equal to the period. With offset 0, such a channel is high on every cycle.
- R7: A channel whose offset is greater than or equal to its period never goes high.
- R8: A channel whose period is 0 is disabled. Its output stays low, and it does not hold back an aligned load.
- R9: Control bit 1 always reads 0. The mode register reads back its bit 1. Channel addresses for channels at index NCH or above read 0, and writes to them are ignored.
- R10: When mode bit 1 is 0, a load waits until every enabled channel has finished the period it was in when the load was written. A channel that finishes early keeps its output low and waits. On the clock after the last enabled channel finishes, all channels start phase 0 of the new settings together.
- R11: An enabled channel's phase advances by one each clock and wraps from period−1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| pwm_out | output | NCH | One pulse output per channel |

## Verification
The hardest situation to reach is an aligned load that lands in the middle of periods of different lengths. One channel has to finish and wait while another is still running, and the release cycle has to be predicted exactly. The stimulus first performs an immediate load with periods 4 and 6. It then issues register writes back to back, so that the aligned load command arrives at a phase the bench knows. From that phase the bench computes each channel's finishing cycle and the common restart cycle, then compares every output cycle of the whole sequence.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = REG_W;

  localparam logic [ADDR_W-1:0] A_SCRATCH = 8'h08;
  localparam logic [ADDR_W-1:0] A_IDENT   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h10;
  localparam logic [ADDR_W-1:0] A_NCHAN   = 8'h14;
  localparam logic [ADDR_W-1:0] A_MODE    = 8'h18;

  localparam logic [REG_W-1:0] IDENT_VAL = 32'h601A_3471;

  // Output level for one channel at a given phase.
  // The phase always stays below the period, so an offset at or past the
  // period can never match.
  function automatic logic pwm_level(input logic [CNT_W-1:0] phase,
                                     input logic [CNT_W-1:0] per,
                                     input logic [CNT_W-1:0] duty,
                                     input logic [CNT_W-1:0] off);
    return (per != '0) && (phase >= off) && ((phase - off) < duty);
  endfunction
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  sh_per  [NCH],
  output logic [CNT_W-1:0]  sh_duty [NCH],
  output logic [CNT_W-1:0]  sh_off  [NCH],
  output logic              core_rst,
  output logic              force_align,
  output logic              load_pulse
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [REG_W-1:0] scratch;
  logic [REG_W-1:0] rd_next;
  logic             w_hit, r_hit;
  logic [IW-1:0]    w_idx, r_idx;

  // Channel array decode: bits 7:6 pick the array, bits 5:2 the channel
  assign w_hit = (wr_addr[7:6] != 2'b00) && (wr_addr[1:0] == 2'b00) && (int'(wr_addr[5:2]) < NCH);
  assign r_hit = (rd_addr[7:6] != 2'b00) && (rd_addr[1:0] == 2'b00) && (int'(rd_addr[5:2]) < NCH);
  assign w_idx = wr_addr[2 +: IW];
  assign r_idx = rd_addr[2 +: IW];

  assign load_pulse = wr_en && (wr_addr == A_CTRL) && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch     <= '0;
      core_rst    <= 1'b1;
      force_align <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        sh_per[i]  <= '0;
        sh_duty[i] <= '0;
        sh_off[i]  <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == A_SCRATCH) scratch     <= wr_data;
      if (wr_addr == A_CTRL)    core_rst    <= wr_data[0];
      if (wr_addr == A_MODE)    force_align <= wr_data[1];
      if (w_hit) begin
        case (wr_addr[7:6])
          2'b01:   sh_per[w_idx]  <= wr_data;
          2'b10:   sh_duty[w_idx] <= wr_data;
          default: sh_off[w_idx]  <= wr_data;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_SCRATCH: rd_next = scratch;
      A_IDENT:   rd_next = IDENT_VAL;
      A_CTRL:    rd_next = {{(REG_W-1){1'b0}}, core_rst};
      A_NCHAN:   rd_next = REG_W'(NCH);
      A_MODE:    rd_next = {{(REG_W-2){1'b0}}, force_align, 1'b0};
      default: begin
        if (r_hit) begin
          case (rd_addr[7:6])
            2'b01:   rd_next = sh_per[r_idx];
            2'b10:   rd_next = sh_duty[r_idx];
            default: rd_next = sh_off[r_idx];
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/pwm_bank_align.sv
module pwm_bank_align #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_pulse,
  input  logic           force_align,
  input  logic           core_rst,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] chan_wrap,
  output logic           commit,
  output logic [NCH-1:0] park
);
  logic           pending;
  logic           pend_eff;
  logic [NCH-1:0] finished;

  assign pend_eff = pending | load_pulse;
  assign finished = park | chan_wrap | ~chan_en;
  assign commit   = pend_eff && (force_align || core_rst || (&finished));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      park    <= '0;
    end else if (commit) begin
      pending <= 1'b0;
      park    <= '0;
    end else if (pend_eff) begin
      pending <= 1'b1;
      park    <= park | chan_wrap;
    end
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_rst,
  input  logic             commit,
  input  logic             park,
  input  logic [CNT_W-1:0] sh_per,
  input  logic [CNT_W-1:0] sh_duty,
  input  logic [CNT_W-1:0] sh_off,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_per,
  output logic [CNT_W-1:0] act_off,
  output logic             chan_en,
  output logic             chan_wrap,
  output logic             pwm
);
  logic [CNT_W-1:0] act_duty;

  assign chan_en   = (act_per != '0);
  assign chan_wrap = chan_en && !park && !core_rst && (cnt == act_per - CNT_W'(1));
  assign pwm       = !core_rst && !park && pwm_level(cnt, act_per, act_duty, act_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per  <= '0;
      act_duty <= '0;
      act_off  <= '0;
    end else if (commit) begin
      act_per  <= sh_per;
      act_duty <= sh_duty;
      act_off  <= sh_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     cnt <= '0;
    else if (core_rst || commit || park || !chan_en) cnt <= '0;
    else if (chan_wrap)                             cnt <= '0;
    else                                            cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [NCH-1:0]    pwm_out
);
  logic [CNT_W-1:0] sh_per  [NCH];
  logic [CNT_W-1:0] sh_duty [NCH];
  logic [CNT_W-1:0] sh_off  [NCH];
  logic [CNT_W-1:0] cnt     [NCH];
  logic [CNT_W-1:0] act_per [NCH];
  logic [CNT_W-1:0] act_off [NCH];
  logic             core_rst, force_align, load_pulse, commit;
  logic [NCH-1:0]   chan_en, chan_wrap, park;

  pwm_bank_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sh_per(sh_per), .sh_duty(sh_duty), .sh_off(sh_off),
    .core_rst(core_rst), .force_align(force_align), .load_pulse(load_pulse)
  );

  pwm_bank_align #(.NCH(NCH)) u_align (
    .clk(clk), .rst_n(rst_n),
    .load_pulse(load_pulse), .force_align(force_align), .core_rst(core_rst),
    .chan_en(chan_en), .chan_wrap(chan_wrap),
    .commit(commit), .park(park)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    pwm_bank_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .core_rst(core_rst), .commit(commit), .park(park[i]),
      .sh_per(sh_per[i]), .sh_duty(sh_duty[i]), .sh_off(sh_off[i]),
      .cnt(cnt[i]), .act_per(act_per[i]), .act_off(act_off[i]),
      .chan_en(chan_en[i]), .chan_wrap(chan_wrap[i]), .pwm(pwm_out[i])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst,
  input logic              commit,
  input logic [NCH-1:0]    park,
  input logic [NCH-1:0]    chan_wrap,
  input logic [NCH-1:0]    pwm_out,
  input logic [CNT_W-1:0]  cnt     [NCH],
  input logic [CNT_W-1:0]  act_per [NCH],
  input logic [CNT_W-1:0]  act_off [NCH],
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [REG_W-1:0]  rd_data
);
  // R4: core reset keeps every output low
  a_r4_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (pwm_out == '0));

  // R1: identification word on the cycle after the read strobe
  a_r1_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_IDENT) |=> (rd_data == IDENT_VAL));

  // R9: the load bit never reads back as 1
  a_r9_load_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_CTRL) |=> !rd_data[1]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R3: a commit restarts every channel at phase 0
    a_r3_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (cnt[i] == '0));

    // R8: a zero period gives a low output
    a_r8_zero_period_low: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per[i] == '0) |-> !pwm_out[i]);

    // R7: an offset at or past the period gives no pulse
    a_r7_offset_past_end: assert property (@(posedge clk) disable iff (!rst_n)
      (act_off[i] >= act_per[i]) |-> !pwm_out[i]);

    // R11: the phase wraps to 0 after period-1
    a_r11_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      chan_wrap[i] |=> (cnt[i] == '0));

    // R11: otherwise a running channel advances by one
    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && !commit && !park[i] && act_per[i] != '0 && !chan_wrap[i])
        |=> (cnt[i] == $past(cnt[i]) + CNT_W'(1)));

    // R10: a channel waiting for an aligned load stays low
    a_r10_park_low: assert property (@(posedge clk) disable iff (!rst_n)
      park[i] |-> !pwm_out[i]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .commit(commit),
  .park(park), .chan_wrap(chan_wrap), .pwm_out(pwm_out),
  .cnt(cnt), .act_per(act_per), .act_off(act_off),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int fails  = 0;
  bit armed  = 1'b0;
  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];

  int unsigned xp[NCH], xd[NCH], xo[NCH];
  int unsigned yp[NCH], yd[NCH], yo[NCH];
  int unsigned zp[NCH], zd[NCH], zo[NCH];

  always #2 clk = ~clk;  // 250 MHz

  pwm_bank #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Expected level, from phase arithmetic with an explicit clip of the duty.
  function automatic logic lvl(input int unsigned per, input int unsigned duty,
                               input int unsigned off, input int k);
    longint unsigned ph, dc, lo;
    if (per == 0) return 1'b0;
    ph = longint'(k) % per;
    dc = (duty > per) ? per : duty;
    lo = off;
    return (lo < per) && (ph >= lo) && (ph < lo + dc);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit arm = 1'b0);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (arm) armed = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic load_shadows(input int unsigned p[NCH], input int unsigned d[NCH], input int unsigned o[NCH]);
    for (int c = 0; c < NCH; c++) begin
      wr(8'h40 + 8'(4*c), p[c]);
      wr(8'h80 + 8'(4*c), d[c]);
      wr(8'hC0 + 8'(4*c), o[c]);
    end
  endtask

  task automatic push_win(input int unsigned p[NCH], input int unsigned d[NCH],
                          input int unsigned o[NCH], input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [NCH-1:0] v;
      for (int c = 0; c < NCH; c++) v[c] = lvl(p[c], d[c], o[c], k);
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each output cycle against the scoreboard queue
  always @(negedge clk) begin
    if (armed) begin
      if (exp_q.size() > 0) begin
        logic [NCH-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(pwm_out == e, t, 32'(pwm_out), 32'(e));
      end
      if (exp_q.size() == 0) armed = 1'b0;
    end
  end

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    xp = '{4, 6, 0, 0};  xd = '{2, 3, 0, 0};  xo = '{1, 2, 0, 0};
    yp = '{5, 3, 0, 7};  yd = '{9, 1, 3, 2};  yo = '{0, 3, 0, 6};
    zp = '{3, 8, 2, 5};  zd = '{1, 4, 1, 0};  zo = '{0, 2, 1, 0};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check(pwm_out == '0, "R4 reset outputs", 32'(pwm_out), 0);
    rd(8'h10, r); check(r == 32'h1, "R4 core reset bit after reset", r, 32'h1);
    rd(8'h18, r); check(r == 32'h0, "R9 mode reg after reset", r, 0);

    // Identification, count, scratchpad
    rd(8'h0C, r); check(r == 32'h601A3471, "R1 ident", r, 32'h601A3471);
    rd(8'h14, r); check(r == NCH, "R1 channel count", r, NCH);
    wr(8'h08, 32'hA5C3_1E0F);
    rd(8'h08, r); check(r == 32'hA5C3_1E0F, "R1 scratchpad", r, 32'hA5C3_1E0F);

    // Unused channel addresses
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h90, 32'h1234_5678);
    rd(8'h50, r); check(r == 0, "R9 unused period slot", r, 0);
    rd(8'h90, r); check(r == 0, "R9 unused duty slot", r, 0);
    rd(8'hD0, r); check(r == 0, "R9 unused offset slot", r, 0);

    // Shadow readback with no output effect
    wr(8'h44, 32'd77);
    rd(8'h44, r); check(r == 32'd77, "R2 shadow readback", r, 77);
    check(pwm_out == '0, "R2 shadow write no effect", 32'(pwm_out), 0);

    // Immediate load of X, then aligned load of Y at a known phase
    wr(8'h18, 32'h2);
    rd(8'h18, r); check(r == 32'h2, "R9 mode readback", r, 2);
    load_shadows(xp, xd, xo);
    begin
      // Sample k is the cycle after edge k; the aligned load strobe sits in
      // sample LD-1 because 1 mode write and 12 shadow writes precede it.
      int LD;
      int fin[NCH];
      int last;
      LD = 14;
      last = LD - 1;
      for (int c = 0; c < NCH; c++) begin
        fin[c] = LD - 1;
        if (xp[c] != 0) begin
          while ((fin[c] % int'(xp[c])) != int'(xp[c]) - 1) fin[c]++;
          if (fin[c] > last) last = fin[c];
        end
      end
      for (int k = 0; k < last + 1 + 20; k++) begin
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) begin
          if (k <= last) v[c] = (xp[c] != 0 && k > fin[c]) ? 1'b0 : lvl(xp[c], xd[c], xo[c], k);
          else           v[c] = lvl(yp[c], yd[c], yo[c], k - last - 1);
        end
        exp_q.push_back(v);
        if (k < LD)         tag_q.push_back("R2 R3 R5 R11");
        else if (k <= last) tag_q.push_back("R10");
        else                tag_q.push_back("R5 R6 R7 R8 R10");
      end
    end
    wr(8'h10, 32'h2, 1'b1);
    wr(8'h18, 32'h0);
    load_shadows(yp, yd, yo);
    wr(8'h10, 32'h2);
    drain();

    rd(8'h10, r); check(r == 32'h0, "R9 load bit self-clears", r, 0);

    // Core reset hold and release
    wr(8'h10, 32'h1);
    for (int i = 0; i < 3; i++) begin
      check(pwm_out == '0, "R4 held in core reset", 32'(pwm_out), 0);
      @(negedge clk);
    end
    push_win(yp, yd, yo, 16, "R4 release restarts at phase 0");
    wr(8'h10, 32'h0, 1'b1);
    drain();

    // Immediate load of Z mid-period
    wr(8'h18, 32'h2);
    load_shadows(zp, zd, zo);
    push_win(zp, zd, zo, 24, "R3 R5 R11");
    wr(8'h10, 32'h2, 1'b1);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule